// File: doc/BRIEF.md
# Parallel Video to CSI-2 Packet Lanes

This block turns a parallel pixel stream (24-bit pixels with a vertical sync, a data-enable and a pixel clock) into CSI-2 low-level packets. The packets are presented on a byte-wide lane interface that can be set to two or four lanes. Every active line is stored in a one-line buffer while it arrives. After the line ends, the line goes out as a single long packet: a header with ECC, the RGB888 payload and a CRC-16 footer. Each falling edge of vertical sync produces two short packets, Frame End and then Frame Start. Frame timing therefore follows that edge and not the sync pulse.

Each data lane has a high-speed request bit. The bit is high for exactly the length of a burst, and the lane rests at LP-11 (request low) between bursts. A separate clock-lane request stays high all the time once reset is released. The downstream D-PHY serializer takes the lane bytes and the request bits. Analog signalling, bit-rate serialization and clock generation are not part of this block.

Top module: `vid2csi_packer`

## Requirements
- R1: On a falling edge of `vsync`, two short packets are sent in this order: Frame End (data ID 0x01), then Frame Start (data ID 0x00). Each header is data ID, 0x00, 0x00, ECC. A rising edge of `vsync`, or `vsync` held high, sends nothing.
- R2: Each interval with `de` high produces exactly one long packet. Its data ID is 0x24 (virtual channel 0), and its word count equals three times the number of pixels stored, sent low byte first.
- R3: Pixels are sent in input order as payload bytes `pix_in[7:0]`, `pix_in[15:8]`, `pix_in[23:16]`.
- R4: Header byte 3 is the CSI-2 ECC over the 24 header bits (data ID in bits 7:0, word count in bits 23:8). Its bits 7:6 are zero. The parity bits match the standard code, so the Frame End header gives 0x07 and the Frame Start header gives 0x00.
- R5: A long packet ends with a CRC-16 over the payload bytes only. The polynomial is x^16+x^12+x^5+1, processed LSB first, seed 0xFFFF, with no final inversion. The CRC is sent low byte first.
- R6: In burst cycle 0, every enabled lane carries 0xB8. Packet byte n (header byte 0 is n=0) goes to lane n mod N in burst cycle 1 + n/N. Unused positions in the last cycle carry 0x00.
- R7: When `lane_sel` is 0, lanes 0 and 1 are used (N=2). When it is 1, all four lanes are used (N=4). Disabled lanes keep their request bit low and their data at 0. The lane count is taken when a burst starts, so a change during a burst has no effect on that burst.
- R8: All enabled lane request bits rise and fall together. A burst lasts 1 + ceil(L/N) cycles, where L is the packet length in bytes. The requests are low for at least one cycle between bursts. `clk_lane_hs` is high in every cycle after reset.
- R9: If `de` rises while the previous line has not finished transmission, `ovf_err` sets and stays set until reset. The new line is discarded and the packet in flight is unaffected. Pixels beyond `MAX_PIX` in one line are dropped and also set `ovf_err`.
- R10: While reset is held, all lane request bits, `clk_lane_hs` and `ovf_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel/byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vsync | input | 1 | Vertical sync, active high |
| de | input | 1 | Data enable, high during active pixels |
| pix_in | input | 24 | Pixel data |
| lane_sel | input | 1 | 0: two lanes, 1: four lanes |
| lane_data | output | 32 | Byte per lane, lane k in bits 8k+7:8k |
| lane_hs | output | 4 | Per-lane high-speed burst request |
| clk_lane_hs | output | 1 | Continuous clock-lane request |
| ovf_err | output | 1 | Sticky line overflow flag |

## Verification
The bench sweeps line lengths from 1 to 12 pixels in both lane modes. This covers every phase at which the CRC bytes can land relative to the lane boundary, so a striper that misplaced the footer, or folded the CRC in the wrong order across a cycle, shows up as a byte mismatch. Frame sync is exercised in both modes to catch FE/FS swaps and wrong ECC bits. A lane-count change in the middle of a burst catches a design that does not latch the lane count at burst start. A line that starts back-to-back with the previous one, and a line longer than the buffer, check that a design neither corrupts the packet in flight nor emits a second packet.

// File: rtl/csi_pack_pkg.sv
package csi_pack_pkg;

    localparam int LANE_MAX = 4;
    localparam logic [5:0] DT_FRAME_START = 6'h00;
    localparam logic [5:0] DT_FRAME_END   = 6'h01;
    localparam logic [5:0] DT_RGB888      = 6'h24;
    localparam logic [7:0] LEAD_BYTE      = 8'hB8;

    typedef enum logic [1:0] {ST_IDLE, ST_SYNC, ST_BODY} eng_state_e;
    typedef enum logic [1:0] {PK_LINE, PK_FEND, PK_FSTART} pkt_kind_e;

    // Parity masks of the 6-bit header code, one per ECC bit
    function automatic logic [7:0] hdr_ecc(input logic [23:0] h);
        logic [7:0] e;
        e[0] = ^(h & 24'hF12CB7);
        e[1] = ^(h & 24'hF2555B);
        e[2] = ^(h & 24'h749A6D);
        e[3] = ^(h & 24'hB8E38E);
        e[4] = ^(h & 24'hDF03F0);
        e[5] = ^(h & 24'hEFFC00);
        e[7:6] = 2'b00;
        return e;
    endfunction

    // One payload byte into the reflected CRC-16 (0x1021 reversed)
    function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        r = c ^ {8'h00, d};
        for (int i = 0; i < 8; i++) begin
            r = r[0] ? ((r >> 1) ^ 16'h8408) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/line_store.sv
module line_store #(
    parameter int MAX_PIX = 64,
    parameter int AW      = $clog2(MAX_PIX)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [23:0]   wr_data,
    input  logic [AW-1:0] rd_addr0,
    input  logic [AW-1:0] rd_addr1,
    output logic [23:0]   rd_pix0,
    output logic [23:0]   rd_pix1
);
    logic [23:0] mem_q [MAX_PIX];

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[wr_addr] <= wr_data;
    end

    always_comb begin
        rd_pix0 = mem_q[rd_addr0];
        rd_pix1 = mem_q[rd_addr1];
    end
endmodule

// File: rtl/vid_capture.sv
module vid_capture #(
    parameter int MAX_PIX = 64,
    parameter int AW      = $clog2(MAX_PIX),
    parameter int CW      = $clog2(MAX_PIX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          vsync,
    input  logic          de,
    input  logic [23:0]   pix_in,
    input  logic          eng_busy,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [23:0]   wr_data,
    output logic          line_done,
    output logic [CW-1:0] line_npix,
    output logic          vs_evt,
    output logic          ovf_err
);
    typedef struct packed {
        logic          vs;
        logic          de;
        logic          drop;
        logic [CW-1:0] cnt;
        logic          done;
        logic [CW-1:0] npix;
        logic          vs_evt;
        logic          ovf;
    } cap_t;

    cap_t cap_d, cap_q;
    logic busy;
    logic de_rise;

    always_comb begin
        cap_d        = cap_q;
        cap_d.done   = 1'b0;
        cap_d.vs_evt = 1'b0;
        cap_d.vs     = vsync;
        cap_d.de     = de;
        wr_en        = 1'b0;
        wr_addr      = cap_q.cnt[AW-1:0];
        wr_data      = pix_in;
        busy         = eng_busy | cap_q.done;
        de_rise      = de & ~cap_q.de;

        if (cap_q.vs && !vsync) cap_d.vs_evt = 1'b1;

        if (de_rise) begin
            if (busy) begin
                cap_d.drop = 1'b1;
                cap_d.ovf  = 1'b1;
            end else begin
                cap_d.drop = 1'b0;
                wr_en      = 1'b1;
                wr_addr    = '0;
                cap_d.cnt  = CW'(1);
            end
        end else if (de && !cap_q.drop) begin
            if (cap_q.cnt < CW'(MAX_PIX)) begin
                wr_en     = 1'b1;
                cap_d.cnt = cap_q.cnt + CW'(1);
            end else begin
                cap_d.ovf = 1'b1;
            end
        end else if (!de && cap_q.de && !cap_q.drop) begin
            cap_d.done = 1'b1;
            cap_d.npix = cap_q.cnt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign line_done = cap_q.done;
    assign line_npix = cap_q.npix;
    assign vs_evt    = cap_q.vs_evt;
    assign ovf_err   = cap_q.ovf;

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_err |=> ovf_err); // R9
    AST_BUSY_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (de_rise && busy) |=> (ovf_err && !line_done)); // R9
endmodule

// File: rtl/burst_engine.sv
module burst_engine
    import csi_pack_pkg::*;
#(
    parameter int MAX_PIX = 64,
    parameter int AW      = $clog2(MAX_PIX),
    parameter int CW      = $clog2(MAX_PIX + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  lane_sel,
    input  logic                  line_done,
    input  logic [CW-1:0]         line_npix,
    input  logic                  vs_evt,
    output logic [AW-1:0]         rd_addr0,
    output logic [AW-1:0]         rd_addr1,
    input  logic [23:0]           rd_pix0,
    input  logic [23:0]           rd_pix1,
    output logic [LANE_MAX*8-1:0] lane_data,
    output logic [LANE_MAX-1:0]   lane_hs,
    output logic                  line_busy
);
    typedef struct packed {
        eng_state_e    state;
        pkt_kind_e     kind;
        logic          wide;
        logic [15:0]   pos;
        logic [CW-1:0] pix;
        logic [2:0]    ph;
        logic [15:0]   crc;
        logic [15:0]   wc;
        logic          line_pend;
        logic          fe_pend;
        logic          fs_pend;
    } eng_t;

    eng_t eng_d, eng_q;

    logic [2:0]  nl;
    logic [7:0]  di_byte;
    logic [15:0] hdr_wc;
    logic [7:0]  ecc_byte;
    logic [15:0] pkt_len;
    logic [15:0] crc_run;
    logic [CW-1:0] pix_nx;

    always_comb begin
        nl      = eng_q.wide ? 3'd4 : 3'd2;
        di_byte = {2'b00, (eng_q.kind == PK_LINE) ? DT_RGB888 :
                          (eng_q.kind == PK_FEND) ? DT_FRAME_END : DT_FRAME_START};
        hdr_wc  = (eng_q.kind == PK_LINE) ? eng_q.wc : 16'h0000;
        ecc_byte = hdr_ecc({hdr_wc, di_byte});
        pkt_len = (eng_q.kind == PK_LINE) ? eng_q.wc + 16'd6 : 16'd4;
        pix_nx  = eng_q.pix + CW'(1);
        rd_addr0 = (eng_q.pix < CW'(MAX_PIX)) ? eng_q.pix[AW-1:0] : AW'(MAX_PIX - 1);
        rd_addr1 = (pix_nx < CW'(MAX_PIX)) ? pix_nx[AW-1:0] : AW'(MAX_PIX - 1);
        line_busy = eng_q.line_pend | ((eng_q.state != ST_IDLE) && (eng_q.kind == PK_LINE));
    end

    always_comb begin
        logic [15:0] s;
        logic [15:0] j;
        logic [2:0]  k;
        logic [2:0]  ph_n;
        logic [7:0]  b;
        eng_d     = eng_q;
        lane_data = '0;
        lane_hs   = '0;
        crc_run   = eng_q.crc;
        s = '0; j = '0; k = '0; b = '0;
        ph_n = eng_q.ph + nl;

        if (line_done) begin
            eng_d.line_pend = 1'b1;
            eng_d.wc        = 16'(line_npix) * 16'd3;
        end
        if (vs_evt) begin
            eng_d.fe_pend = 1'b1;
            eng_d.fs_pend = 1'b1;
        end

        case (eng_q.state)
            ST_IDLE: begin
                if (eng_q.line_pend || eng_q.fe_pend || eng_q.fs_pend) begin
                    eng_d.state = ST_SYNC;
                    eng_d.wide  = lane_sel;
                    eng_d.pos   = '0;
                    eng_d.pix   = '0;
                    eng_d.ph    = '0;
                    eng_d.crc   = 16'hFFFF;
                    if (eng_q.line_pend) begin
                        eng_d.kind      = PK_LINE;
                        eng_d.line_pend = 1'b0;
                    end else if (eng_q.fe_pend) begin
                        eng_d.kind    = PK_FEND;
                        eng_d.fe_pend = 1'b0;
                    end else begin
                        eng_d.kind    = PK_FSTART;
                        eng_d.fs_pend = 1'b0;
                    end
                end
            end
            ST_SYNC: begin
                for (int l = 0; l < LANE_MAX; l++) begin
                    if (3'(l) < nl) begin
                        lane_hs[l]         = 1'b1;
                        lane_data[l*8 +: 8] = LEAD_BYTE;
                    end
                end
                eng_d.state = ST_BODY;
            end
            default: begin
                for (int l = 0; l < LANE_MAX; l++) begin
                    if (3'(l) < nl) begin
                        lane_hs[l] = 1'b1;
                        s = eng_q.pos + 16'(l);
                        j = s - 16'd4;
                        k = eng_q.ph + 3'(l);
                        b = 8'h00;
                        if (s < 16'd4) begin
                            case (s[1:0])
                                2'd0:    b = di_byte;
                                2'd1:    b = hdr_wc[7:0];
                                2'd2:    b = hdr_wc[15:8];
                                default: b = ecc_byte;
                            endcase
                        end else if (eng_q.kind == PK_LINE && j < eng_q.wc) begin
                            case (k)
                                3'd0:    b = rd_pix0[7:0];
                                3'd1:    b = rd_pix0[15:8];
                                3'd2:    b = rd_pix0[23:16];
                                3'd3:    b = rd_pix1[7:0];
                                3'd4:    b = rd_pix1[15:8];
                                default: b = rd_pix1[23:16];
                            endcase
                            crc_run = crc_byte(crc_run, b);
                        end else if (eng_q.kind == PK_LINE && j == eng_q.wc) begin
                            b = crc_run[7:0];
                        end else if (eng_q.kind == PK_LINE && j == eng_q.wc + 16'd1) begin
                            b = crc_run[15:8];
                        end
                        lane_data[l*8 +: 8] = b;
                    end
                end
                eng_d.crc = crc_run;
                eng_d.pos = eng_q.pos + 16'(nl);
                if (eng_q.pos >= 16'd4) begin
                    eng_d.pix = eng_q.pix;
                    if (ph_n >= 3'd3) begin
                        ph_n      = ph_n - 3'd3;
                        eng_d.pix = eng_d.pix + CW'(1);
                    end
                    if (ph_n >= 3'd3) begin
                        ph_n      = ph_n - 3'd3;
                        eng_d.pix = eng_d.pix + CW'(1);
                    end
                    eng_d.ph = ph_n;
                end
                if (eng_q.pos + 16'(nl) >= pkt_len) eng_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) eng_q <= '0;
        else        eng_q <= eng_d;
    end

    AST_SYNC_FROM_LP: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_q.state == ST_SYNC) |-> ($past(eng_q.state) == ST_IDLE)); // R8
    AST_WIDTH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_q.state == ST_BODY) |-> $stable(eng_q.wide)); // R7
    AST_FS_FOLLOWS_FE: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_q.state == ST_IDLE && eng_q.fe_pend) |-> eng_q.fs_pend); // R1
endmodule

// File: rtl/vid2csi_packer.sv
module vid2csi_packer
    import csi_pack_pkg::*;
#(
    parameter int MAX_PIX = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        vsync,
    input  logic        de,
    input  logic [23:0] pix_in,
    input  logic        lane_sel,
    output logic [31:0] lane_data,
    output logic [3:0]  lane_hs,
    output logic        clk_lane_hs,
    output logic        ovf_err
);
    localparam int AW = $clog2(MAX_PIX);
    localparam int CW = $clog2(MAX_PIX + 1);

    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [23:0]   wr_data;
    logic [AW-1:0] rd_addr0, rd_addr1;
    logic [23:0]   rd_pix0, rd_pix1;
    logic          line_done;
    logic [CW-1:0] line_npix;
    logic          vs_evt;
    logic          line_busy;
    logic          clk_on_d, clk_on_q;

    vid_capture #(.MAX_PIX(MAX_PIX), .AW(AW), .CW(CW)) u_capture (
        .clk(clk), .rst_n(rst_n), .vsync(vsync), .de(de), .pix_in(pix_in),
        .eng_busy(line_busy), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .line_done(line_done), .line_npix(line_npix), .vs_evt(vs_evt), .ovf_err(ovf_err)
    );

    line_store #(.MAX_PIX(MAX_PIX), .AW(AW)) u_store (
        .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr0(rd_addr0), .rd_addr1(rd_addr1), .rd_pix0(rd_pix0), .rd_pix1(rd_pix1)
    );

    burst_engine #(.MAX_PIX(MAX_PIX), .AW(AW), .CW(CW)) u_engine (
        .clk(clk), .rst_n(rst_n), .lane_sel(lane_sel), .line_done(line_done),
        .line_npix(line_npix), .vs_evt(vs_evt), .rd_addr0(rd_addr0), .rd_addr1(rd_addr1),
        .rd_pix0(rd_pix0), .rd_pix1(rd_pix1), .lane_data(lane_data), .lane_hs(lane_hs),
        .line_busy(line_busy)
    );

    always_comb clk_on_d = 1'b1;

    always_ff @(posedge clk) begin
        if (!rst_n) clk_on_q <= 1'b0;
        else        clk_on_q <= clk_on_d;
    end

    assign clk_lane_hs = clk_on_q;

    AST_CLK_CONT: assert property (@(posedge clk) disable iff (!rst_n)
        clk_lane_hs |=> clk_lane_hs); // R8
    AST_LANE_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
        (|lane_hs) |-> (lane_hs == 4'h3 || lane_hs == 4'hF)); // R7
endmodule

// File: tb/vid2csi_packer_bench.sv
`timescale 1ns/1ps
module vid2csi_packer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vsync = 1'b0;
    logic        de = 1'b0;
    logic [23:0] pix_in = '0;
    logic        lane_sel = 1'b0;
    logic [31:0] lane_data;
    logic [3:0]  lane_hs;
    logic        clk_lane_hs;
    logic        ovf_err;

    int n_chk = 0;
    int n_err = 0;
    logic [7:0]  exp_q [$];
    logic [23:0] pix_q [$];
    bit          mon_on = 1'b0;
    int          clk_gaps = 0;

    always #2 clk = ~clk;

    vid2csi_packer u_vid2csi_packer (
        .clk(clk), .rst_n(rst_n), .vsync(vsync), .de(de), .pix_in(pix_in),
        .lane_sel(lane_sel), .lane_data(lane_data), .lane_hs(lane_hs),
        .clk_lane_hs(clk_lane_hs), .ovf_err(ovf_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] ecc_ref(input logic [23:0] h);
        logic [5:0] cols [24];
        logic [5:0] acc;
        cols = '{6'h07, 6'h0B, 6'h0D, 6'h0E, 6'h13, 6'h15, 6'h16, 6'h19,
                 6'h1A, 6'h1C, 6'h23, 6'h25, 6'h26, 6'h29, 6'h2A, 6'h2C,
                 6'h31, 6'h32, 6'h34, 6'h38, 6'h1F, 6'h2F, 6'h37, 6'h3B};
        acc = '0;
        for (int i = 0; i < 24; i++) if (h[i]) acc = acc ^ cols[i];
        return {2'b00, acc};
    endfunction

    function automatic logic [23:0] pix_val(input int ln, input int i);
        return {8'(ln * 17 + i * 3), 8'(i * 29 + 5), 8'(ln ^ (i * 11))};
    endfunction

    task automatic build_short(input logic [7:0] di);
        exp_q.delete();
        exp_q.push_back(di);
        exp_q.push_back(8'h00);
        exp_q.push_back(8'h00);
        exp_q.push_back(ecc_ref({16'h0000, di}));
    endtask

    // header, payload in pixel order (low byte first), CRC computed bitwise
    task automatic build_long(input int npx);
        logic [15:0] wc;
        logic [15:0] c;
        logic [7:0]  b;
        logic        fb;
        wc = 16'(3 * npx);
        c  = 16'hFFFF;
        exp_q.delete();
        exp_q.push_back(8'h24);
        exp_q.push_back(wc[7:0]);
        exp_q.push_back(wc[15:8]);
        exp_q.push_back(ecc_ref({wc, 8'h24}));
        for (int p = 0; p < npx; p++) begin
            for (int by = 0; by < 3; by++) begin
                b = pix_q[p][by*8 +: 8];
                exp_q.push_back(b);
                for (int bit_i = 0; bit_i < 8; bit_i++) begin
                    fb = c[0] ^ b[bit_i];
                    c  = c >> 1;
                    if (fb) c = c ^ 16'h8408;
                end
            end
        end
        exp_q.push_back(c[7:0]);
        exp_q.push_back(c[15:8]);
    endtask

    task automatic drive_line(input int npx, input int ln, input bit keep);
        if (keep) pix_q.delete();
        for (int i = 0; i < npx; i++) begin
            @(negedge clk);
            de = 1'b1;
            pix_in = pix_val(ln, i);
            if (keep) pix_q.push_back(pix_in);
        end
        @(negedge clk);
        de = 1'b0;
        pix_in = '0;
    endtask

    task automatic expect_burst(input int nl, input string req);
        int waitc;
        int ncyc;
        int idx;
        logic [31:0] ew;
        logic [3:0]  em;
        waitc = 0;
        ncyc = (exp_q.size() + nl - 1) / nl;
        em = (nl == 4) ? 4'hF : 4'h3;
        do begin
            @(negedge clk);
            waitc++;
        end while (lane_hs == 4'h0 && waitc < 400);
        chk({req, " burst start"}, {28'h0, lane_hs}, {28'h0, em});
        ew = (nl == 4) ? 32'hB8B8B8B8 : 32'h0000B8B8;
        chk({req, " R6 lead byte"}, lane_data, ew);
        for (int c = 1; c <= ncyc; c++) begin
            @(negedge clk);
            ew = '0;
            for (int l = 0; l < nl; l++) begin
                idx = (c - 1) * nl + l;
                ew[l*8 +: 8] = (idx < exp_q.size()) ? exp_q[idx] : 8'h00;
            end
            chk({req, " R6 R7 lane request"}, {28'h0, lane_hs}, {28'h0, em});
            chk({req, " R6 lane bytes"}, lane_data, ew);
        end
        @(negedge clk);
        chk({req, " R8 LP gap after burst"}, {28'h0, lane_hs}, 32'h0);
    endtask

    task automatic expect_quiet(input int ncyc, input string req);
        logic seen;
        seen = 1'b0;
        for (int i = 0; i < ncyc; i++) begin
            @(negedge clk);
            if (lane_hs != 4'h0) seen = 1'b1;
        end
        chk(req, {31'h0, seen}, 32'h0);
    endtask

    task automatic do_reset();
        mon_on = 1'b0;
        rst_n = 1'b0;
        de = 1'b0;
        vsync = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10 lane_hs in reset", {28'h0, lane_hs}, 32'h0);
        chk("R10 clk lane in reset", {31'h0, clk_lane_hs}, 32'h0);
        chk("R10 ovf in reset", {31'h0, ovf_err}, 32'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        mon_on = 1'b1;
    endtask

    task automatic frame_sync(input int nl);
        @(negedge clk);
        vsync = 1'b1;
        expect_quiet(12, "R1 nothing while vsync high");
        vsync = 1'b0;
        build_short(8'h01);
        chk("R4 FE ecc", {24'h0, exp_q[3]}, 32'h07);
        expect_burst(nl, "R1 R4 frame end");
        build_short(8'h00);
        expect_burst(nl, "R1 R4 frame start");
    endtask

    // clock lane monitor (R8)
    always @(negedge clk) begin
        if (mon_on && rst_n && clk_lane_hs !== 1'b1) clk_gaps++;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog R8 actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        do_reset();

        lane_sel = 1'b0;
        frame_sync(2);
        lane_sel = 1'b1;
        frame_sync(4);

        // sweep of line lengths in both lane modes (R2 R3 R5 R6)
        for (int m = 0; m < 2; m++) begin
            lane_sel = (m == 1);
            for (int n = 1; n <= 12; n++) begin
                drive_line(n, n + m * 20, 1'b1);
                build_long(n);
                expect_burst(m ? 4 : 2, "R2 R3 R5 line");
            end
        end

        // lane count change mid-burst has no effect (R7)
        lane_sel = 1'b1;
        drive_line(10, 77, 1'b1);
        build_long(10);
        fork
            expect_burst(4, "R7 lane_sel change mid-burst");
            begin
                repeat (5) @(negedge clk);
                lane_sel = 1'b0;
            end
        join
        drive_line(5, 78, 1'b1);
        build_long(5);
        expect_burst(2, "R7 new lane count");
        chk("R9 ovf clear in normal use", {31'h0, ovf_err}, 32'h0);

        // line longer than the buffer (R9)
        lane_sel = 1'b1;
        drive_line(70, 90, 1'b1);
        build_long(64);
        expect_burst(4, "R9 long line truncated");
        chk("R9 ovf after long line", {31'h0, ovf_err}, 32'h1);

        do_reset();

        // back-to-back lines: second one discarded (R9)
        lane_sel = 1'b1;
        drive_line(6, 5, 1'b1);
        build_long(6);
        fork
            expect_burst(4, "R9 packet in flight intact");
            drive_line(5, 6, 1'b0);
        join
        chk("R9 ovf on early de", {31'h0, ovf_err}, 32'h1);
        expect_quiet(80, "R9 dropped line not sent");
        chk("R9 ovf sticky", {31'h0, ovf_err}, 32'h1);

        chk("R8 clk lane continuous", clk_gaps, 32'h0);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule